// File: doc/BRIEF.md
# Smart-card clock-rate divisor calculator

This block turns a pair of 4-bit rate indices, a clock-rate index and a baud-adjust index, into the number of card-clock cycles per elementary time unit. A receiver for an asynchronous smart-card link needs this number. The block looks up a clock-rate factor F and an adjust factor D from two fixed sixteen-entry tables. It then divides F by D, or multiplies F by D, depending on the adjust index. The result is range-checked before it is kept in a 10-bit output register.

A computation starts on a one-cycle load strobe. One cycle later the outcome appears. On an accepted result the ratio register takes the new value and a valid flag pulses. On a rejected result an error flag pulses and the ratio register keeps its old value. A separate default request recomputes the ratio for the indices used right after a card reset (clock-rate index 1, adjust index 1). That ratio is 372, which is also the value the register holds out of reset.

Top module: `fd_ratio_calc`

## Requirements
- R1: While reset is asserted and right after it is released, `ratio_o` is 372 and `valid_o` and `err_o` are 0.
- R2: The F table, indexed by `fi_i` 0..15, is 372, 372, 558, 744, 1116, 1488, 1860, 0, 0, 512, 768, 1024, 1536, 2048, 0, 0. The D table, indexed by `di_i` 0..15, is 0, 1, 2, 4, 8, 16, 32, 64, 12, 20, 2, 4, 8, 16, 32, 64. A table entry of 0 marks a reserved index.
- R3: For `di_i` below 8 the candidate ratio is F / D, with the remainder dropped.
- R4: For `di_i` of 8 or above the candidate ratio is F × D.
- R5: A load whose F entry or D entry is 0 is rejected. `err_o` is 1 for exactly the cycle after the strobe, `valid_o` stays 0, and `ratio_o` is unchanged.
- R6: A candidate ratio of 0, or of 1024 or more, is rejected in the same way as in R5. 1024 itself is rejected and 1023 would be accepted.
- R7: An accepted load sets `ratio_o` to the candidate in the cycle after the strobe. `valid_o` is 1 for exactly that cycle.
- R8: `dflt_i` computes the ratio for indices 1 and 1 and gives 372 with a `valid_o` pulse in the next cycle. It wins over a `load_i` in the same cycle, whatever `fi_i` and `di_i` are.
- R9: In a cycle after which neither `load_i` nor `dflt_i` was sampled high, `valid_o` and `err_o` are 0 and `ratio_o` keeps its value.
- R10: `valid_o` and `err_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Strobe: compute the ratio from `fi_i` / `di_i` |
| fi_i | input | 4 | Clock-rate index |
| di_i | input | 4 | Baud-adjust index |
| dflt_i | input | 1 | Strobe: compute the post-reset default ratio |
| ratio_o | output | 10 | Last accepted clocks-per-ETU ratio |
| valid_o | output | 1 | One-cycle pulse: a new ratio was accepted |
| err_o | output | 1 | One-cycle pulse: a request was rejected |

## Verification
Every one of the 256 index pairs is loaded back to back. This separates the divide path from the multiply path, reserved entries from in-range ones, and truncating quotients such as 744/64 from exact ones. It also brings out the 1024 boundary, which index pairs 9/10 and 13/2 reach exactly. Loads separated by idle gaps show that the ratio holds and that the flags stay low when no strobe is sampled. Default requests, alone and together with a load of a rejected pair, show that the default wins and still gives 372.

// File: rtl/fd_ratio_pkg.sv
package fd_ratio_pkg;

  localparam int F_W   = 12;  // widest F entry is 2048
  localparam int D_W   = 7;   // widest D entry is 64
  localparam int SH_W  = 3;   // log2 of the largest divisor
  localparam int PROD_W = F_W + D_W;

  typedef struct packed {
    logic [D_W-1:0]  val;
    logic [SH_W-1:0] shift;  // divisor as a shift when mul == 0
    logic            mul;    // 1: multiply F by val
  } d_entry_t;

  function automatic logic [F_W-1:0] f_entry(input logic [3:0] idx);
    case (idx)
      4'd0, 4'd1: f_entry = F_W'(372);
      4'd2:       f_entry = F_W'(558);
      4'd3:       f_entry = F_W'(744);
      4'd4:       f_entry = F_W'(1116);
      4'd5:       f_entry = F_W'(1488);
      4'd6:       f_entry = F_W'(1860);
      4'd9:       f_entry = F_W'(512);
      4'd10:      f_entry = F_W'(768);
      4'd11:      f_entry = F_W'(1024);
      4'd12:      f_entry = F_W'(1536);
      4'd13:      f_entry = F_W'(2048);
      default:    f_entry = '0;
    endcase
  endfunction

  function automatic d_entry_t d_entry(input logic [3:0] idx);
    d_entry_t e;
    e.mul = idx[3];
    case (idx)
      4'd8:    begin e.val = D_W'(12); e.shift = '0; end
      4'd9:    begin e.val = D_W'(20); e.shift = '0; end
      4'd0:    begin e.val = '0;       e.shift = '0; end
      default: begin
        // power-of-two entries: 1..64 below 8, 2..64 from 10 upward
        e.shift = SH_W'(idx[2:0] - 3'd1);
        e.val   = D_W'(1) << (idx[2:0] - 3'd1);
      end
    endcase
    return e;
  endfunction

endpackage

// File: rtl/fd_table_lookup.sv
module fd_table_lookup
  import fd_ratio_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] fi_idx,
  input  logic [IDX_W-1:0] di_idx,
  output logic [F_W-1:0]   f_val,
  output d_entry_t         d_ent
);

  always_comb begin
    f_val = f_entry(4'(fi_idx));
    d_ent = d_entry(4'(di_idx));
  end

endmodule

// File: rtl/fd_ratio_arith.sv
module fd_ratio_arith
  import fd_ratio_pkg::*;
#(
  parameter int RATIO_W = 10
) (
  input  logic [F_W-1:0]     f_val,
  input  d_entry_t           d_ent,
  output logic [RATIO_W-1:0] ratio,
  output logic               ok
);

  localparam logic [PROD_W-1:0] LIMIT = PROD_W'(1) << RATIO_W;

  logic [PROD_W-1:0] product;
  logic [PROD_W-1:0] quotient;
  logic [PROD_W-1:0] result;

  always_comb begin
    product  = PROD_W'(f_val) * PROD_W'(d_ent.val);
    quotient = PROD_W'(f_val >> d_ent.shift);
    result   = d_ent.mul ? product : quotient;
    ok       = (f_val != '0) && (d_ent.val != '0) &&
               (result != '0) && (result < LIMIT);
    ratio    = result[RATIO_W-1:0];
  end

endmodule

// File: rtl/fd_ratio_calc.sv
module fd_ratio_calc
  import fd_ratio_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter int RATIO_W    = 10,
  parameter int DEFAULT_FI = 1,
  parameter int DEFAULT_DI = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [IDX_W-1:0]   fi_i,
  input  logic [IDX_W-1:0]   di_i,
  input  logic               dflt_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               valid_o,
  output logic               err_o
);

  localparam d_entry_t        DEF_D     = d_entry(4'(DEFAULT_DI));
  localparam logic [F_W-1:0]  DEF_F     = f_entry(4'(DEFAULT_FI));
  localparam logic [RATIO_W-1:0] RST_RATIO = RATIO_W'(DEF_F >> DEF_D.shift);

  logic [IDX_W-1:0]   fi_sel, di_sel;
  logic [F_W-1:0]     f_val;
  d_entry_t           d_ent;
  logic [RATIO_W-1:0] cand;
  logic               cand_ok;
  logic               strobe;

  logic [RATIO_W-1:0] ratio_q, ratio_d;
  logic               valid_q, valid_d;
  logic               err_q, err_d;

  // default request overrides the load indices
  always_comb begin
    fi_sel = dflt_i ? IDX_W'(DEFAULT_FI) : fi_i;
    di_sel = dflt_i ? IDX_W'(DEFAULT_DI) : di_i;
    strobe = load_i | dflt_i;
  end

  fd_table_lookup #(.IDX_W(IDX_W)) u_lookup (
    .fi_idx (fi_sel),
    .di_idx (di_sel),
    .f_val  (f_val),
    .d_ent  (d_ent)
  );

  fd_ratio_arith #(.RATIO_W(RATIO_W)) u_arith (
    .f_val (f_val),
    .d_ent (d_ent),
    .ratio (cand),
    .ok    (cand_ok)
  );

  always_comb begin
    ratio_d = ratio_q;
    valid_d = 1'b0;
    err_d   = 1'b0;
    if (strobe) begin
      if (cand_ok) begin
        ratio_d = cand;
        valid_d = 1'b1;
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= RST_RATIO;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
      if (strobe) begin
        ratio_q <= ratio_d;
      end
    end
  end

  assign ratio_o = ratio_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;

  // R10
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && err_o));

  // R5
  err_holds_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ratio_o == $past(ratio_o));

  // R6
  valid_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ratio_o != '0);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_i || dflt_i) |=> (!valid_o && !err_o && $stable(ratio_o)));

  // R8
  dflt_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dflt_i |=> (valid_o && ratio_o == RST_RATIO));

endmodule

// File: tb/fd_ratio_calc_tb.sv
module fd_ratio_calc_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_i = 1'b0;
  logic [3:0] fi_i = '0;
  logic [3:0] di_i = '0;
  logic       dflt_i = 1'b0;
  logic [9:0] ratio_o;
  logic       valid_o, err_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  fd_ratio_calc u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .fi_i(fi_i), .di_i(di_i),
    .dflt_i(dflt_i), .ratio_o(ratio_o), .valid_o(valid_o), .err_o(err_o)
  );

  // R2 tables, written from the requirement
  function automatic int f_of(int i);
    int t[16] = '{372, 372, 558, 744, 1116, 1488, 1860, 0,
                  0, 512, 768, 1024, 1536, 2048, 0, 0};
    return t[i];
  endfunction
  function automatic int d_of(int i);
    int t[16] = '{0, 1, 2, 4, 8, 16, 32, 64,
                  12, 20, 2, 4, 8, 16, 32, 64};
    return t[i];
  endfunction

  // behavioural reference model
  int    exp_ratio = 372;
  bit    exp_valid = 0;
  bit    exp_err   = 0;
  string exp_tag   = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_ratio = 372; exp_valid = 0; exp_err = 0; exp_tag = "R1";
    end else if (dflt_i) begin
      exp_ratio = 372; exp_valid = 1; exp_err = 0; exp_tag = "R8";
    end else if (load_i) begin
      int f, d, r;
      f = f_of(int'(fi_i));
      d = d_of(int'(di_i));
      if (f == 0 || d == 0) begin
        exp_valid = 0; exp_err = 1; exp_tag = "R5 (R2 tables)";
      end else begin
        r = (di_i < 8) ? f / d : f * d;
        if (r == 0 || r >= 1024) begin
          exp_valid = 0; exp_err = 1;
          exp_tag = (di_i < 8) ? "R6 R3" : "R6 R4";
        end else begin
          exp_ratio = r; exp_valid = 1; exp_err = 0;
          exp_tag = (di_i < 8) ? "R7 R3" : "R7 R4";
        end
      end
    end else begin
      exp_valid = 0; exp_err = 0; exp_tag = "R9";
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      n_checks++;
      if (int'(ratio_o) != exp_ratio) begin
        n_fail++;
        $display("FAIL %s ratio_o actual %0d expected %0d", exp_tag, ratio_o, exp_ratio);
      end
      n_checks++;
      if (valid_o != exp_valid || err_o != exp_err) begin
        n_fail++;
        $display("FAIL %s valid/err actual %0b/%0b expected %0b/%0b",
                 exp_tag, valid_o, err_o, exp_valid, exp_err);
      end
      n_checks++;
      if (valid_o && err_o) begin
        n_fail++;
        $display("FAIL R10 valid/err actual 1/1 expected not both");
      end
    end
  end

  task automatic load(input int fi, input int di);
    @(negedge clk);
    load_i = 1'b1; fi_i = 4'(fi); di_i = 4'(di);
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    // R1: reset state
    idle(3);
    rst_n = 1'b1;
    idle(3);
    // R3 / R4 / R5 / R6 / R7: all index pairs back to back
    @(negedge clk);
    load_i = 1'b1;
    for (int fi = 0; fi < 16; fi++) begin
      for (int di = 0; di < 16; di++) begin
        fi_i = 4'(fi); di_i = 4'(di);
        @(negedge clk);
      end
    end
    load_i = 1'b0;
    idle(2);
    // gapped loads, R9 between them
    load(3, 7);   // 744/64 truncates to 11
    idle(4);
    load(9, 10);  // 1024 rejected, R6 boundary
    idle(3);
    load(13, 2);  // 1024 rejected
    load(13, 3);  // 512
    load(7, 1);   // reserved F, R5
    idle(2);
    // R8: default alone and with a competing load
    @(negedge clk); dflt_i = 1'b1;
    @(negedge clk); dflt_i = 1'b0;
    load(12, 6);  // 48
    @(negedge clk); dflt_i = 1'b1; load_i = 1'b1; fi_i = 4'd2; di_i = 4'd9;
    @(negedge clk); dflt_i = 1'b0; load_i = 1'b0;
    idle(3);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

endmodule